// File: doc/BRIEF.md
# PHY Power-Up Sequencer With DLL Lock

This block brings the analog front end of a storage-interface PHY up or down without software in the loop. A single-cycle power-on request runs the full bring-up. The power-down-bar line and the DLL enable are first forced low. After a settling gap the PHY is powered. The sequencer then waits for pad calibration, programs a 2-bit DLL frequency band chosen from the measured card clock rate, enables the DLL and, when a clock is present, waits for the DLL to report lock. A power-off request performs only the opening low phase.

All waits are counted in microseconds. The microsecond tick comes from the system clock through a prescaler of `TICK_DIV` cycles. Both timeouts end the sequence with an error code instead of hanging. A rate-warning output flags card clock rates that the DLL cannot track accurately. Busy, done, error and the error code give the requester a simple completion handshake.

Top module: `phy_pwr_seq`

## Requirements
- R1: During and after reset, `phy_pdb`, `phy_dll_en`, `busy`, `done`, `err` and `rate_warn` are 0, and `phy_freq_sel` and `err_code` are 0.
- R2: A request sampled while idle is accepted at that clock edge. At that edge `busy` rises, `phy_pdb` is driven low, and `done`, `err` and `err_code` clear. On the following edge `phy_dll_en` is driven low.
- R3: An accepted power-off request finishes at the edge that drives `phy_dll_en` low, with `done`=1, `err`=0 and `err_code`=0. It leaves `phy_freq_sel` unchanged and clears `rate_warn`.
- R4: For a power-on request, `phy_pdb` rises exactly SETTLE_US*TICK_DIV+1 cycles after the edge that drove `phy_dll_en` low.
- R5: Once `phy_pdb` is high, `cal_done` is sampled on every edge. At the edge where it is seen high, `phy_freq_sel` takes the band code. `phy_dll_en` rises on the next edge.
- R6: In some cycles `cal_done` stays low for all of the CAL_TIMEOUT_US*TICK_DIV+1 edges after `phy_pdb` rises. The sequence then ends with `done`=1, `err`=1 and `err_code`=1. In that case `phy_dll_en` stays low and `phy_freq_sel` is unchanged.
- R7: The band code follows the rate captured at acceptance. Rates 1 to 74,999,999 Hz give code 1. Rates 75,000,000 to 124,999,999 Hz give code 2. Rates 125,000,000 to 174,999,999 Hz give code 3. A rate of 0, or any rate of 175,000,000 Hz and above, gives code 0.
- R8: On acceptance of a power-on request, `rate_warn` is set when either of two conditions holds. The first is a rate above 200 MHz. The second is a rate above 50 MHz that lies more than 15 MHz from its band's nominal value. The nominal values are 200, 50, 100 and 150 MHz for codes 0 to 3.
- R9: With a captured rate of 0, the sequence finishes successfully (`done`=1, `err`=0) at the same edge where `phy_dll_en` rises. It does not wait for `dll_ready`.
- R10: With a nonzero rate, `dll_ready` is sampled on each edge after `phy_dll_en` rises. The sequence finishes successfully at the edge where it is seen high.
- R11: In some cycles `dll_ready` stays low for all of the LOCK_TIMEOUT_US*TICK_DIV+1 edges after `phy_dll_en` rises. The sequence then ends with `done`=1, `err`=1 and `err_code`=2.
- R12: Requests are ignored while `busy` is high. A request is ignored if it leaves the sequence, `phy_freq_sel` and `rate_warn` unaffected. If both requests arrive together while idle, the power-off request wins.
- R13: `busy` falls at the finishing edge. `done`, `err` and `err_code` then hold until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_on_req | input | 1 | Start a power-up sequence |
| pwr_off_req | input | 1 | Start a power-down sequence |
| clk_rate_hz | input | RATE_W | Measured card clock rate in Hz, 0 for no clock |
| cal_done | input | 1 | Pad calibration complete |
| dll_ready | input | 1 | DLL locked |
| phy_pdb | output | 1 | PHY power-down-bar (1 = powered) |
| phy_dll_en | output | 1 | DLL enable |
| phy_freq_sel | output | 2 | DLL frequency band code |
| rate_warn | output | 1 | Captured rate is unsuitable for accurate DLL tuning |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence has finished |
| err | output | 1 | Last sequence ended in a timeout |
| err_code | output | 2 | 0 success, 1 calibration timeout, 2 DLL lock timeout |

## Verification
A state register stuck in the wrong phase or a mis-sized prescaler moves the `phy_pdb` or `phy_dll_en` edge by one or more cycles. Either fault could also end a wait early. The per-cycle reference comparison sees this on the first edge that diverges. A wrong band threshold or warning comparison appears at `phy_freq_sel` when calibration completes, or at `rate_warn` one cycle after acceptance. The rate sweep sits on both sides of each band boundary for that reason. A lost busy qualifier lets a stray request restart the sequence, which pulls `phy_pdb` low mid-sequence in the cycle after the stray pulse.

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq #(
  parameter int TICK_DIV        = 100,
  parameter int SETTLE_US       = 3,
  parameter int CAL_TIMEOUT_US  = 50,
  parameter int LOCK_TIMEOUT_US = 50000,
  parameter int RATE_W          = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on_req,
  input  logic              pwr_off_req,
  input  logic [RATE_W-1:0] clk_rate_hz,
  input  logic              cal_done,
  input  logic              dll_ready,
  output logic              phy_pdb,
  output logic              phy_dll_en,
  output logic [1:0]        phy_freq_sel,
  output logic              rate_warn,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code
);

  localparam int PRE_W  = $clog2(TICK_DIV + 1);
  localparam int US_MAX = (LOCK_TIMEOUT_US > CAL_TIMEOUT_US) ?
                          ((LOCK_TIMEOUT_US > SETTLE_US) ? LOCK_TIMEOUT_US : SETTLE_US) :
                          ((CAL_TIMEOUT_US > SETTLE_US) ? CAL_TIMEOUT_US : SETTLE_US);
  localparam int US_W   = $clog2(US_MAX + 2);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [US_W-1:0]  SET_LIM  = US_W'(SETTLE_US);
  localparam logic [US_W-1:0]  CAL_LIM  = US_W'(CAL_TIMEOUT_US);
  localparam logic [US_W-1:0]  LCK_LIM  = US_W'(LOCK_TIMEOUT_US);
  localparam logic [63:0] MHZ = 64'd1_000_000;

  typedef enum logic [2:0] {S_IDLE, S_PDB_LO, S_SETTLE, S_CAL, S_FREQ, S_LOCK} st_t;

  st_t               st;
  logic              op_on;
  logic [63:0]       rate_q;
  logic [PRE_W-1:0]  pre;
  logic [US_W-1:0]   us;

  function automatic logic [1:0] band_of(input logic [63:0] r);
    if (r == 64'd0)            return 2'd0;
    else if (r < 75 * MHZ)     return 2'd1;
    else if (r < 125 * MHZ)    return 2'd2;
    else if (r < 175 * MHZ)    return 2'd3;
    else                       return 2'd0;
  endfunction

  function automatic logic warn_of(input logic [63:0] r);
    logic [63:0] nom;
    logic [63:0] dif;
    case (band_of(r))
      2'd1:    nom = 50 * MHZ;
      2'd2:    nom = 100 * MHZ;
      2'd3:    nom = 150 * MHZ;
      default: nom = 200 * MHZ;
    endcase
    dif = (r > nom) ? r - nom : nom - r;
    return ((r > 50 * MHZ) && (dif > 15 * MHZ)) || (r > 200 * MHZ);
  endfunction

  wire        tick   = (pre == PRE_LAST);
  wire        accept = (st == S_IDLE) && (pwr_on_req || pwr_off_req);
  wire [63:0] rate_in = 64'(clk_rate_hz);

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      op_on        <= 1'b0;
      rate_q       <= '0;
      pre          <= '0;
      us           <= '0;
      phy_pdb      <= 1'b0;
      phy_dll_en   <= 1'b0;
      phy_freq_sel <= 2'd0;
      rate_warn    <= 1'b0;
      done         <= 1'b0;
      err          <= 1'b0;
      err_code     <= 2'd0;
    end else begin
      if (tick) begin
        pre <= '0;
        us  <= us + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
      case (st)
        S_IDLE: if (accept) begin
          st        <= S_PDB_LO;
          op_on     <= !pwr_off_req;
          rate_q    <= rate_in;
          rate_warn <= !pwr_off_req && warn_of(rate_in);
          phy_pdb   <= 1'b0;
          done      <= 1'b0;
          err       <= 1'b0;
          err_code  <= 2'd0;
        end
        S_PDB_LO: begin
          phy_dll_en <= 1'b0;
          pre        <= '0;
          us         <= '0;
          if (op_on) st <= S_SETTLE;
          else begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        S_SETTLE: if (us == SET_LIM) begin
          st      <= S_CAL;
          phy_pdb <= 1'b1;
          pre     <= '0;
          us      <= '0;
        end
        S_CAL: if (cal_done) begin
          st           <= S_FREQ;
          phy_freq_sel <= band_of(rate_q);
        end else if (us == CAL_LIM) begin
          st       <= S_IDLE;
          done     <= 1'b1;
          err      <= 1'b1;
          err_code <= 2'd1;
        end
        S_FREQ: begin
          phy_dll_en <= 1'b1;
          pre        <= '0;
          us         <= '0;
          if (rate_q == 64'd0) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else st <= S_LOCK;
        end
        S_LOCK: if (dll_ready) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end else if (us == LCK_LIM) begin
          st       <= S_IDLE;
          done     <= 1'b1;
          err      <= 1'b1;
          err_code <= 2'd2;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phy_pwr_seq_chk.sv
module phy_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       phy_pdb,
  input logic       phy_dll_en,
  input logic [1:0] phy_freq_sel,
  input logic       rate_warn,
  input logic       cal_done,
  input logic       done,
  input logic       err,
  input logic [1:0] err_code
);

  // R2
  pdb_low_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !phy_pdb);

  // R5
  dll_after_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_dll_en) |-> phy_pdb);

  // R5
  freq_only_on_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phy_freq_sel) |-> ($past(busy) && $past(cal_done)));

  // R6
  cal_fail_no_dll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && err_code == 2'd1) |-> !phy_dll_en);

  // R12
  warn_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rate_warn));

  // R13
  status_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> ($stable(done) && $stable(err) && $stable(err_code)));

endmodule

bind phy_pwr_seq phy_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .phy_pdb(phy_pdb),
  .phy_dll_en(phy_dll_en), .phy_freq_sel(phy_freq_sel), .rate_warn(rate_warn),
  .cal_done(cal_done), .done(done), .err(err), .err_code(err_code)
);

// File: tb/sim_phy_pwr_seq.sv
`timescale 1ns/100ps
module sim_phy_pwr_seq;
  localparam int TD = 4, SU = 3, CT = 10, LT = 30;

  logic clk = 0, rst_n = 0, on_r = 0, off_r = 0, cal = 0, rdy = 0;
  logic [31:0] rate = 0;
  logic pdb, den, warn, bsy, dn, er;
  logic [1:0] fs, ec;
  int checks = 0, failures = 0, cyc = 0;
  int cal_lat = -1, lock_lat = -1, cc = 0, lc = 0;

  always #2.5 clk = ~clk;

  phy_pwr_seq #(.TICK_DIV(TD), .SETTLE_US(SU), .CAL_TIMEOUT_US(CT),
                .LOCK_TIMEOUT_US(LT), .RATE_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(on_r), .pwr_off_req(off_r),
    .clk_rate_hz(rate), .cal_done(cal), .dll_ready(rdy), .phy_pdb(pdb),
    .phy_dll_en(den), .phy_freq_sel(fs), .rate_warn(warn), .busy(bsy),
    .done(dn), .err(er), .err_code(ec));

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int ph = 0, n = 0, m_on = 0;
  longint m_rate = 0;
  int e_pdb = 0, e_den = 0, e_fs = 0, e_warn = 0, e_bsy = 0, e_dn = 0, e_er = 0, e_ec = 0;

  function automatic int code_for(longint r);
    if (r >= 1 && r <= 74_999_999) return 1;
    if (r >= 75_000_000 && r <= 124_999_999) return 2;
    if (r >= 125_000_000 && r <= 174_999_999) return 3;
    return 0;
  endfunction

  function automatic int warn_for(longint r);
    longint nomv[4] = '{200_000_000, 50_000_000, 100_000_000, 150_000_000};
    longint d = r - nomv[code_for(r)];
    if (d < 0) d = -d;
    return ((r > 50_000_000 && d > 15_000_000) || r > 200_000_000) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      ph = 0; e_pdb = 0; e_den = 0; e_fs = 0; e_warn = 0; e_bsy = 0; e_dn = 0; e_er = 0; e_ec = 0;
    end else begin
      if (ph == 0) begin
        if (on_r || off_r) begin
          m_on = off_r ? 0 : 1; m_rate = rate;
          e_bsy = 1; e_pdb = 0; e_dn = 0; e_er = 0; e_ec = 0;
          e_warn = m_on ? warn_for(m_rate) : 0;
          ph = 1;
        end
      end else if (ph == 1) begin
        e_den = 0;
        if (m_on == 0) begin e_bsy = 0; e_dn = 1; ph = 0; end
        else begin ph = 2; n = 0; end
      end else if (ph == 2) begin
        if (n == SU * TD) begin e_pdb = 1; ph = 3; n = 0; end else n++;
      end else if (ph == 3) begin
        if (cal) begin e_fs = code_for(m_rate); ph = 4; end
        else if (n == CT * TD) begin e_bsy = 0; e_dn = 1; e_er = 1; e_ec = 1; ph = 0; end
        else n++;
      end else if (ph == 4) begin
        e_den = 1;
        if (m_rate == 0) begin e_bsy = 0; e_dn = 1; ph = 0; end
        else begin ph = 5; n = 0; end
      end else begin
        if (rdy) begin e_bsy = 0; e_dn = 1; ph = 0; end
        else if (n == LT * TD) begin e_bsy = 0; e_dn = 1; e_er = 1; e_ec = 2; ph = 0; end
        else n++;
      end
    end
  end

  // analog stubs and per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      cmp("R2 R4 pdb", pdb, e_pdb);
      cmp("R5 R9 dll_en", den, e_den);
      cmp("R7 freq_sel", fs, e_fs);
      cmp("R8 rate_warn", warn, e_warn);
      cmp("R12 busy", bsy, e_bsy);
      cmp("R13 done", dn, e_dn);
      cmp("R6 R11 err", er, e_er);
      cmp("R6 R11 err_code", ec, e_ec);
    end
    if (!pdb) cc = 0; else cc++;
    cal = (cal_lat >= 0 && cc > cal_lat);
    if (!den) lc = 0; else lc++;
    rdy = (lock_lat >= 0 && lc > lock_lat);
    if (cyc > 60000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 60000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run(bit on, bit off, longint r, int cl, int ll);
    @(negedge clk);
    rate = r[31:0]; on_r = on; off_r = off; cal_lat = cl; lock_lat = ll;
    @(negedge clk);
    on_r = 0; off_r = 0;
    for (int k = 0; k < 2000 && bsy; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1 pdb", pdb, 0); cmp("R1 dll_en", den, 0); cmp("R1 busy", bsy, 0);
    cmp("R1 done", dn, 0); cmp("R1 freq", fs, 0); cmp("R1 err_code", ec, 0);
    rst_n = 1;
    run(0, 1, 0, -1, -1);
    cmp("R3 off done", dn, 1); cmp("R3 off err", er, 0); cmp("R3 off freq", fs, 0);
    run(1, 0, 100_000_000, 5, 8);
    cmp("R10 ok", {dn, er}, 2'b10); cmp("R7 100M", fs, 2); cmp("R8 100M", warn, 0); cmp("R10 dll_en", den, 1);
    run(1, 0, 0, 2, -1);
    cmp("R9 done", {dn, er}, 2'b10); cmp("R9 freq", fs, 0); cmp("R9 dll_en", den, 1);
    run(1, 0, 80_000_000, -1, -1);
    cmp("R6 code", ec, 1); cmp("R6 freq", fs, 0); cmp("R8 80M", warn, 1);
    run(1, 0, 150_000_000, 3, -1);
    cmp("R11 code", ec, 2); cmp("R7 150M", fs, 3); cmp("R8 150M", warn, 0);
    run(1, 0, 48_000_000, 1, 1);      cmp("R7 48M", fs, 1); cmp("R8 48M", warn, 0);
    run(1, 0, 74_999_999, 1, 1);      cmp("R7 edge1", fs, 1); cmp("R8 edge1", warn, 1);
    run(1, 0, 75_000_000, 1, 1);      cmp("R7 edge2", fs, 2); cmp("R8 edge2", warn, 1);
    run(1, 0, 175_000_000, 1, 1);     cmp("R7 edge3", fs, 0); cmp("R8 edge3", warn, 1);
    run(1, 0, 190_000_000, 1, 1);     cmp("R7 190M", fs, 0); cmp("R8 190M", warn, 0);
    run(1, 0, 250_000_000, 1, 1);     cmp("R7 250M", fs, 0); cmp("R8 250M", warn, 1);
    // R12: stray requests during a running sequence
    @(negedge clk); rate = 100_000_000; on_r = 1; cal_lat = 4; lock_lat = 6;
    @(negedge clk); on_r = 0;
    repeat (5) @(negedge clk); off_r = 1; rate = 10;
    @(negedge clk); off_r = 0;
    repeat (10) @(negedge clk); on_r = 1;
    @(negedge clk); on_r = 0;
    for (int k = 0; k < 500 && bsy; k++) @(negedge clk);
    cmp("R12 ignored freq", fs, 2); cmp("R12 ignored ok", {dn, er}, 2'b10); cmp("R12 warn", warn, 0);
    run(1, 1, 100_000_000, 1, 1);
    cmp("R12 off wins pdb", pdb, 0); cmp("R12 off wins dll", den, 0); cmp("R12 off wins freq", fs, 2);
    repeat (20) @(negedge clk);
    cmp("R13 held", dn, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule